// File: doc/BRIEF.md
# Power Management Capability Registers

This block holds the power management capability of a bridge function that hosts a hot-plug controller. It exposes two configuration dwords through a simple 32-bit register port made up of an offset, byte enables, a write strobe, write data and combinational read data. The first dword is the capability header. The second dword is the status/control word, which carries the power state, the PME enable bit and the PME status bit.

The function accepts only two power states, D0 and D3hot. A write that tries to select a reserved state completes on the port, but the power state does not change. When the hot-plug controller requests an operation while the function is in D3hot, the PME status bit is latched. The PME enable bit does not affect the status bit. It only decides whether a one-cycle message request pulse goes out. Both PME bits are sticky: a power-on reset clears them, and a functional reset does not.

A strap input tells the block whether the hot-plug controller is present. The strap selects the next-capability pointer that the header returns.

Top module: `pm_cap_regs`

## Requirements
- R1: Reading offset `HDR_OFF` (default 6Ch) returns 01h in bits 7:0. Bits 31:16 of that dword read zero.
- R2: Bits 15:8 of the header read 78h when `hp_strap` is 1 and D8h when `hp_strap` is 0.
- R3: At offset `CTL_OFF` (default 70h), bits 31:16, 14:9 and 7:2 always read zero. Any other offset reads all zeros.
- R4: The power state is held in bits 1:0 of the control dword and mirrored on `pwr_state`. Encoding 00b is D0 and 11b is D3hot. A power-on reset sets the field to 00b.
- R5: A write whose bits 1:0 are 01b or 10b leaves the power state at its previous value.
- R6: PME status (bit 15) becomes 1 on the clock edge where `hp_req` is 1 while the power state is 11b. This happens whatever PME enable holds. `hp_req` in D0 does not set the bit.
- R7: Writing 1 to bit 15 clears PME status. Writing 0 to bit 15 leaves it unchanged.
- R8: PME enable (bit 8) is read/write.
- R9: `pme_msg` is high for exactly one cycle, in the cycle after an edge where PME status and PME enable together go from not both 1 to both 1. It stays low at all other times.
- R10: Taking `frst_n` low returns the power state to 00b and keeps both PME bits. Taking `por_n` low clears all three fields.
- R11: Bits 1:0 are written only when `cfg_be[0]` is set. Bits 8 and 15 are written only when `cfg_be[1]` is set.
- R12: If a hot-plug request in D3hot and a write-one-to-clear of bit 15 fall on the same edge, PME status stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| frst_n | input | 1 | Functional reset, active low, sampled on the clock |
| cfg_addr | input | ADDR_W | Dword-aligned byte offset |
| cfg_be | input | 4 | Byte enables |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational from `cfg_addr` |
| hp_strap | input | 1 | 1 when the hot-plug controller is enabled |
| hp_req | input | 1 | Hot-plug operation request |
| pwr_state | output | 2 | Current power state |
| pme_msg | output | 1 | PME message request pulse |

## Verification
A write or a hot-plug request takes effect on the clock edge that samples it. The new register value therefore shows on `cfg_rdata` and `pwr_state` in the following cycle. `pme_msg` is registered, so it rises in that same following cycle and falls one cycle later. The bench drives every stimulus at a falling edge and holds it across one rising edge. It reads back at the next falling edge, and for the message it samples again one falling edge later to confirm that the pulse lasts a single cycle. Read data is combinational, so each read check places the offset first and samples a moment later within the same low phase.

// File: rtl/pm_cap_regs.sv
module pm_cap_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HDR_OFF = 8'h6C,
  parameter logic [ADDR_W-1:0] CTL_OFF = 8'h70,
  parameter logic [7:0] NPTR_HP = 8'h78,
  parameter logic [7:0] NPTR_NOHP = 8'hD8,
  parameter logic [7:0] CAP_ID = 8'h01
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              frst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              hp_strap,
  input  logic              hp_req,
  output logic [1:0]        pwr_state,
  output logic              pme_msg
);

  localparam logic [1:0] PS_D0 = 2'b00;
  localparam logic [1:0] PS_D3 = 2'b11;

  logic [1:0] pwr_q;
  logic       pme_sts_q, pme_en_q;
  logic       pme_sts_d, pme_en_d;

  wire wr_ctl  = cfg_wr && (cfg_addr == CTL_OFF);
  wire lane0   = wr_ctl && cfg_be[0];
  wire lane1   = wr_ctl && cfg_be[1];
  wire ps_ok   = (cfg_wdata[1:0] == PS_D0) || (cfg_wdata[1:0] == PS_D3);
  wire set_ev  = hp_req && (pwr_q == PS_D3);
  wire clr_ev  = lane1 && cfg_wdata[15];

  assign pme_sts_d = set_ev | (pme_sts_q & ~clr_ev);
  assign pme_en_d  = lane1 ? cfg_wdata[8] : pme_en_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pme_sts_q <= 1'b0;
      pme_en_q  <= 1'b0;
    end else begin
      pme_sts_q <= pme_sts_d;
      pme_en_q  <= pme_en_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pwr_q   <= PS_D0;
      pme_msg <= 1'b0;
    end else if (!frst_n) begin
      pwr_q   <= PS_D0;
      pme_msg <= 1'b0;
    end else begin
      if (lane0 && ps_ok) pwr_q <= cfg_wdata[1:0];
      pme_msg <= pme_sts_d & pme_en_d & ~(pme_sts_q & pme_en_q);
    end
  end

  wire [7:0] nptr = hp_strap ? NPTR_HP : NPTR_NOHP;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == HDR_OFF)
      cfg_rdata = {16'h0000, nptr, CAP_ID};
    else if (cfg_addr == CTL_OFF)
      cfg_rdata = {16'h0000, pme_sts_q, 6'b0, pme_en_q, 6'b0, pwr_q};
  end

  assign pwr_state = pwr_q;

endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HDR_OFF = 8'h6C,
  parameter logic [ADDR_W-1:0] CTL_OFF = 8'h70
) (
  input logic              clk,
  input logic              por_n,
  input logic              frst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic              cfg_wr,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              hp_req,
  input logic [1:0]        pwr_state,
  input logic              pme_msg,
  input logic              pme_sts,
  input logic              pme_en
);

  p_cap_id_r1: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_addr == HDR_OFF) |-> (cfg_rdata[7:0] == 8'h01 && cfg_rdata[31:16] == 16'h0));

  p_ro_zero_r3: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_addr == CTL_OFF) |-> (cfg_rdata[31:16] == 16'h0 && cfg_rdata[14:9] == 6'h0 && cfg_rdata[7:2] == 6'h0));

  p_pwr_legal_r4: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_state == 2'b00) || (pwr_state == 2'b11));

  p_reserved_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    (frst_n && cfg_wr && cfg_addr == CTL_OFF && cfg_be[0] && (cfg_wdata[1:0] == 2'b01 || cfg_wdata[1:0] == 2'b10))
    |=> $stable(pwr_state));

  p_set_d3_r6: assert property (@(posedge clk) disable iff (!por_n)
    (hp_req && pwr_state == 2'b11) |=> pme_sts);

  p_msg_gate_r9: assert property (@(posedge clk) disable iff (!por_n)
    pme_msg |-> (pme_sts && pme_en));

  p_msg_single_r9: assert property (@(posedge clk) disable iff (!por_n)
    pme_msg |=> !pme_msg);

  p_frst_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    (!frst_n && !hp_req && !cfg_wr) |=> ($stable(pme_sts) && $stable(pme_en) && pwr_state == 2'b00));

endmodule

bind pm_cap_regs pm_cap_regs_chk #(.ADDR_W(ADDR_W), .HDR_OFF(HDR_OFF), .CTL_OFF(CTL_OFF)) u_chk (
  .clk(clk), .por_n(por_n), .frst_n(frst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
  .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hp_req(hp_req),
  .pwr_state(pwr_state), .pme_msg(pme_msg), .pme_sts(pme_sts_q), .pme_en(pme_en_q)
);

// File: tb/pm_cap_regs_tb_top.sv
module pm_cap_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] HDR = 8'h6C;
  localparam logic [7:0] CTL = 8'h70;
  localparam int NV = 9;
  // {be, wdata, expected control dword}
  localparam logic [67:0] VEC [NV] = '{
    {4'h1, 32'h0000_0003, 32'h0000_0003},
    {4'h1, 32'h0000_0001, 32'h0000_0003},
    {4'h1, 32'h0000_0002, 32'h0000_0003},
    {4'h2, 32'h0000_0000, 32'h0000_0003},
    {4'h1, 32'h0000_0000, 32'h0000_0000},
    {4'h1, 32'h0000_0002, 32'h0000_0000},
    {4'hF, 32'hFFFF_FFFE, 32'h0000_0100},
    {4'h1, 32'hFFFF_FFFF, 32'h0000_0103},
    {4'h2, 32'h0000_0000, 32'h0000_0003}
  };

  logic clk = 0, por_n = 0, frst_n = 1;
  logic [7:0] cfg_addr = '0;
  logic [3:0] cfg_be = '0;
  logic cfg_wr = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic hp_strap = 1, hp_req = 0;
  logic [1:0] pwr_state;
  logic pme_msg;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_cap_regs dut_i (
    .clk(clk), .por_n(por_n), .frst_n(frst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hp_strap(hp_strap),
    .hp_req(hp_req), .pwr_state(pwr_state), .pme_msg(pme_msg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  // drive at a falling edge, the rising edge applies it, return at the next falling edge
  task automatic cyc(input logic wr, input logic [3:0] be, input logic [31:0] d, input logic hp);
    cfg_addr = CTL; cfg_wr = wr; cfg_be = be; cfg_wdata = d; hp_req = hp;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0; hp_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk("R4 reset pwr_state", {30'b0, pwr_state}, 32'h0);
    rd("R3 reset control dword", CTL, 32'h0);
    rd("R1 R2 header strap=1", HDR, 32'h0000_7801);
    hp_strap = 0;
    rd("R2 header strap=0", HDR, 32'h0000_D801);
    hp_strap = 1;
    rd("R3 unmapped offset", 8'h74, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VEC[i][67:64], VEC[i][63:32], 1'b0);
      rd($sformatf("R5 R8 R11 vector %0d", i), CTL, VEC[i][31:0]);
      chk($sformatf("R4 vector %0d pwr_state", i), {30'b0, pwr_state}, {30'b0, VEC[i][1:0]});
    end

    // D3hot, enable 0
    cyc(1'b0, 4'h0, 32'h0, 1'b1);
    chk("R9 no msg while disabled", {31'b0, pme_msg}, 32'h0);
    rd("R6 status set with enable 0", CTL, 32'h0000_8003);
    cyc(1'b1, 4'h1, 32'h0000_8003, 1'b0);
    rd("R11 clear without lane 1", CTL, 32'h0000_8003);
    cyc(1'b1, 4'h2, 32'h0000_0100, 1'b0);
    chk("R9 msg on enable with status set", {31'b0, pme_msg}, 32'h1);
    rd("R7 write 0 keeps status", CTL, 32'h0000_8103);
    @(negedge clk);
    chk("R9 msg one cycle", {31'b0, pme_msg}, 32'h0);
    cyc(1'b1, 4'h2, 32'h0000_8100, 1'b0);
    rd("R7 write 1 clears status", CTL, 32'h0000_0103);
    chk("R9 no msg on clear", {31'b0, pme_msg}, 32'h0);
    cyc(1'b0, 4'h0, 32'h0, 1'b1);
    chk("R9 msg on set with enable 1", {31'b0, pme_msg}, 32'h1);
    rd("R6 status set with enable 1", CTL, 32'h0000_8103);
    @(negedge clk);
    chk("R9 msg drops", {31'b0, pme_msg}, 32'h0);
    cyc(1'b1, 4'h2, 32'h0000_8100, 1'b1);
    rd("R12 set wins over clear", CTL, 32'h0000_8103);
    chk("R9 no msg when already set", {31'b0, pme_msg}, 32'h0);

    frst_n = 0;
    @(negedge clk);
    frst_n = 1;
    rd("R10 functional reset keeps sticky", CTL, 32'h0000_8100);
    chk("R10 functional reset pwr_state", {30'b0, pwr_state}, 32'h0);

    cyc(1'b1, 4'h2, 32'h0000_8100, 1'b0);
    cyc(1'b0, 4'h0, 32'h0, 1'b1);
    rd("R6 no set in D0", CTL, 32'h0000_0100);
    chk("R9 no msg in D0", {31'b0, pme_msg}, 32'h0);

    cyc(1'b1, 4'hF, 32'h0000_8103, 1'b0);
    cyc(1'b0, 4'h0, 32'h0, 1'b1);
    por_n = 0;
    @(negedge clk);
    por_n = 1;
    rd("R10 power-on reset clears all", CTL, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule